// File: doc/BRIEF.md
# Triple-DES Iterative Block Cipher Core

This block encrypts or decrypts one 64-bit block with Triple-DES in the encrypt-decrypt-encrypt arrangement. It takes three 64-bit keys. A single DES round engine, one round per clock, is shared across all three DES passes, so a whole operation takes 48 round cycles. A sequencer picks the key and the direction for each pass. A key schedule register rotates the two 28-bit key halves to produce each round's 48-bit subkey.

The user drives the three keys, the block, and the direction on `decrypt`, then pulses `start`. The core captures the direction and the parity-stripped keys on the edge that accepts `start`, so the inputs may change after that edge. The result appears on `dout` together with a one-cycle `done` pulse. It stays on `dout` until the next operation is accepted. If all three keys are equal, the core gives plain single-DES results. If the third key equals the first, the core gives the two-key variant.

Top module: `tdes_core`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `dout` is all zeros until an operation completes.
- R2: With `decrypt` = 0, `dout` is DES-encrypt under key3 of DES-decrypt under key2 of DES-encrypt under key1 of `din`. The passes use key1, then key2, then key3.
- R3: With `decrypt` = 1, `dout` is DES-decrypt under key1 of DES-encrypt under key2 of DES-decrypt under key3 of `din`. This is the exact inverse of R2 for the same keys.
- R4: Bit 0 of every key byte (bits 0, 8, ..., 56 of each key port) has no effect on `dout`.
- R5: With key1 = key2 = key3, the result equals standard single DES under that key. For example, key 133457799BBCDFF1 encrypts 0123456789ABCDEF to 85E813540F0AB405.
- R6: `done` is 1 for exactly one cycle. It rises on the 48th rising edge after the edge that accepts `start`, and it is 0 on every edge in between.
- R7: A `start` that arrives while an operation is in flight is ignored. Changes to `din`, `decrypt` or any key after the accepting edge do not alter the result or its timing.
- R8: Between operations `dout` holds the last result unchanged.
- R9: A `start` that is high in the cycle in which `done` is 1 is accepted on the next edge, with no idle cycle needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| decrypt | input | 1 | 0 = encrypt (E-D-E), 1 = decrypt (D-E-D) |
| key1 | input | 64 | First key, byte LSBs are parity and ignored |
| key2 | input | 64 | Second key |
| key3 | input | 64 | Third key |
| din | input | 64 | Input block |
| dout | output | 64 | Result block, held until next accepted start |
| done | output | 1 | One-cycle pulse when `dout` is valid |

## Verification
The in-RTL assertions watch the sequencing on every cycle. They check the following:
- `done` is a single-cycle pulse that only occurs when idle.
- A run never stops or changes direction before its 48th round.
- Each pass hands over to the next with the round counter back at zero.
- An encrypt pass rotates its key halves a full turn.
- The result register is frozen whenever the core is idle.

Whether the ciphertext is actually correct can only be shown by the bench. It compares against known single-DES answers and against its own model for random key and data sets. The bench also covers the following, which depend on whole-operation scenarios rather than on any one cycle:
- round trips from encryption back to decryption;
- parity-bit insensitivity;
- starts and input changes during a busy run;
- back-to-back starts in the done cycle.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

  localparam int BLK_W  = 64;
  localparam int HALF_W = 32;
  localparam int CD_W   = 56;
  localparam int HCD_W  = 28;
  localparam int SUBK_W = 48;

  // Selection lists: entry i (0-based) sits at [8*(N-1-i) +: 8], values are
  // 1-based source bit numbers counted from the MSB.
  localparam logic [8*56-1:0] KEY_SEL_TBL = {
    8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9,  8'd1,
    8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18, 8'd10, 8'd2,
    8'd59, 8'd51, 8'd43, 8'd35, 8'd27, 8'd19, 8'd11, 8'd3,
    8'd60, 8'd52, 8'd44, 8'd36, 8'd63, 8'd55, 8'd47, 8'd39,
    8'd31, 8'd23, 8'd15, 8'd7,  8'd62, 8'd54, 8'd46, 8'd38,
    8'd30, 8'd22, 8'd14, 8'd6,  8'd61, 8'd53, 8'd45, 8'd37,
    8'd29, 8'd21, 8'd13, 8'd5,  8'd28, 8'd20, 8'd12, 8'd4};

  localparam logic [8*48-1:0] SUBK_SEL_TBL = {
    8'd14, 8'd17, 8'd11, 8'd24, 8'd1,  8'd5,  8'd3,  8'd28,
    8'd15, 8'd6,  8'd21, 8'd10, 8'd23, 8'd19, 8'd12, 8'd4,
    8'd26, 8'd8,  8'd16, 8'd7,  8'd27, 8'd20, 8'd13, 8'd2,
    8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55, 8'd30, 8'd40,
    8'd51, 8'd45, 8'd33, 8'd48, 8'd44, 8'd49, 8'd39, 8'd56,
    8'd34, 8'd53, 8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32};

  localparam logic [8*32-1:0] MIX_SEL_TBL = {
    8'd16, 8'd7,  8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
    8'd1,  8'd15, 8'd23, 8'd26, 8'd5,  8'd18, 8'd31, 8'd10,
    8'd2,  8'd8,  8'd24, 8'd14, 8'd32, 8'd27, 8'd3,  8'd9,
    8'd19, 8'd13, 8'd30, 8'd6,  8'd22, 8'd11, 8'd4,  8'd25};

  // Substitution boxes: nibble at index row*16+col, index 0 leftmost.
  localparam logic [255:0] SBOX_0 =
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D;
  localparam logic [255:0] SBOX_1 =
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9;
  localparam logic [255:0] SBOX_2 =
    256'hA09E63F51DC7B428_D70934A6285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C;
  localparam logic [255:0] SBOX_3 =
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E;
  localparam logic [255:0] SBOX_4 =
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453;
  localparam logic [255:0] SBOX_5 =
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D;
  localparam logic [255:0] SBOX_6 =
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C;
  localparam logic [255:0] SBOX_7 =
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B;

  // Source bit (1-based from MSB) of output position i of the entry permutation.
  function automatic int entry_src(input int i);
    int r;
    int c;
    r = i / 8;
    c = i % 8;
    return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * c;
  endfunction

  function automatic logic [63:0] block_in_perm(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[63 - i] = x[6'(64 - entry_src(i))];
    return y;
  endfunction

  function automatic logic [63:0] block_out_perm(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[6'(64 - entry_src(i))] = x[63 - i];
    return y;
  endfunction

  function automatic logic [55:0] key_compress(input logic [63:0] k);
    logic [55:0] y;
    for (int i = 0; i < 56; i++)
      y[55 - i] = k[6'(64 - int'(KEY_SEL_TBL[8*(55-i) +: 8]))];
    return y;
  endfunction

  function automatic logic [47:0] subkey_pick(input logic [55:0] cd);
    logic [47:0] y;
    for (int i = 0; i < 48; i++)
      y[47 - i] = cd[6'(56 - int'(SUBK_SEL_TBL[8*(47-i) +: 8]))];
    return y;
  endfunction

  function automatic logic [47:0] half_expand(input logic [31:0] h);
    logic [47:0] y;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 6; k++)
        y[47 - (6 * j + k)] = h[5'(32 - (((4 * j + k + 31) % 32) + 1))];
    return y;
  endfunction

  function automatic logic [31:0] half_mix(input logic [31:0] s);
    logic [31:0] y;
    for (int i = 0; i < 32; i++)
      y[31 - i] = s[5'(32 - int'(MIX_SEL_TBL[8*(31-i) +: 8]))];
    return y;
  endfunction

  function automatic logic [3:0] sbox_lookup(input int n, input logic [5:0] b);
    logic [255:0] t;
    int idx;
    case (n)
      0: t = SBOX_0;
      1: t = SBOX_1;
      2: t = SBOX_2;
      3: t = SBOX_3;
      4: t = SBOX_4;
      5: t = SBOX_5;
      6: t = SBOX_6;
      default: t = SBOX_7;
    endcase
    idx = int'({b[5], b[0]}) * 16 + int'(b[4:1]);
    return t[8'(255 - 4 * idx) -: 4];
  endfunction

  function automatic logic [31:0] round_mix(input logic [31:0] h, input logic [47:0] sk);
    logic [47:0] x;
    logic [31:0] s;
    x = half_expand(h) ^ sk;
    for (int j = 0; j < 8; j++) s[31 - 4 * j -: 4] = sbox_lookup(j, x[47 - 6 * j -: 6]);
    return half_mix(s);
  endfunction

  // Rotation amount of the round with 0-based index i.
  function automatic int rot_step(input int i);
    return (i == 0 || i == 1 || i == 8 || i == 15) ? 1 : 2;
  endfunction

  function automatic logic [55:0] cd_rotl(input logic [55:0] cd, input int n);
    logic [27:0] c;
    logic [27:0] d;
    c = cd[55:28];
    d = cd[27:0];
    if (n == 1) return {c[26:0], c[27], d[26:0], d[27]};
    return {c[25:0], c[27:26], d[25:0], d[27:26]};
  endfunction

  function automatic logic [55:0] cd_rotr(input logic [55:0] cd, input int n);
    logic [27:0] c;
    logic [27:0] d;
    c = cd[55:28];
    d = cd[27:0];
    if (n == 1) return {c[0], c[27:1], d[0], d[27:1]};
    return {c[1:0], c[27:2], d[1:0], d[27:2]};
  endfunction

endpackage

// File: rtl/tdes_sequencer.sv
module tdes_sequencer
  import tdes_pkg::*;
#(
  parameter int PASSES = 3,
  parameter int ROUNDS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      decrypt,
  output logic                      accept,
  output logic                      step,
  output logic                      last_rnd,
  output logic                      fin_rnd,
  output logic                      pass_dec,
  output logic [$clog2(ROUNDS)-1:0] rnd,
  output logic [$clog2(PASSES)-1:0] kidx_next,
  output logic                      done
);
  localparam int RW = $clog2(ROUNDS);
  localparam int PW = $clog2(PASSES);

  logic          run_q;
  logic          mode_q;
  logic          done_q;
  logic [PW-1:0] pass_q;
  logic [RW-1:0] rnd_q;

  assign accept    = start && !run_q;
  assign step      = run_q;
  assign last_rnd  = (rnd_q == RW'(ROUNDS - 1));
  assign fin_rnd   = run_q && last_rnd && (pass_q == PW'(PASSES - 1));
  assign pass_dec  = mode_q ^ pass_q[0];
  assign rnd       = rnd_q;
  assign kidx_next = mode_q ? (PW'(PASSES - 2) - pass_q) : (pass_q + 1'b1);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= '0;
      rnd_q  <= '0;
    end else begin
      done_q <= fin_rnd;
      if (accept) begin
        run_q  <= 1'b1;
        mode_q <= decrypt;
        pass_q <= '0;
        rnd_q  <= '0;
      end else if (run_q) begin
        rnd_q <= last_rnd ? '0 : rnd_q + 1'b1;
        if (last_rnd) begin
          if (fin_rnd) run_q  <= 1'b0;
          else         pass_q <= pass_q + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !fin_rnd) |=> (run_q && mode_q == $past(mode_q)));

  assert_pass_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && last_rnd && !fin_rnd) |=> (rnd_q == '0 && pass_q == $past(pass_q) + 1'b1));

endmodule

// File: rtl/tdes_key_sched.sv
module tdes_key_sched
  import tdes_pkg::*;
#(
  parameter int ROUNDS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CD_W-1:0]           load_cd,
  input  logic                      step,
  input  logic                      last,
  input  logic                      dec,
  input  logic [$clog2(ROUNDS)-1:0] rnd,
  output logic [SUBK_W-1:0]         subkey
);
  logic [CD_W-1:0] cd_q;
  logic [CD_W-1:0] cd_round;

  // Encrypt: rotate left before use. Decrypt: first round unrotated, then
  // undo the encrypt rotations in reverse order.
  always_comb begin
    if (!dec)             cd_round = cd_rotl(cd_q, rot_step(int'(rnd)));
    else if (rnd == '0)   cd_round = cd_q;
    else                  cd_round = cd_rotr(cd_q, rot_step(ROUNDS - int'(rnd)));
  end

  assign subkey = subkey_pick(cd_round);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cd_q <= '0;
    else if (load)  cd_q <= load_cd;
    else if (step)  cd_q <= cd_round;
  end

  // A full encrypt pass turns both halves by 28: the last round's value
  // equals what was loaded at the start of the pass.
  assert_enc_full_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !dec) |-> (cd_round == $past(cd_q, 15)));

endmodule

// File: rtl/tdes_round_engine.sv
module tdes_round_engine
  import tdes_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BLK_W-1:0]   blk_in,
  input  logic               step,
  input  logic               last,
  input  logic [SUBK_W-1:0]  subkey,
  output logic [BLK_W-1:0]   blk_out
);
  logic [HALF_W-1:0] l_q;
  logic [HALF_W-1:0] r_q;
  logic [HALF_W-1:0] f_out;

  assign f_out = round_mix(r_q, subkey);

  // The last round of a pass keeps the halves in place, so the register
  // holds the pre-output block, which is also the next pass's start state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= '0;
      r_q <= '0;
    end else if (load) begin
      {l_q, r_q} <= block_in_perm(blk_in);
    end else if (step) begin
      if (last) begin
        l_q <= l_q ^ f_out;
      end else begin
        l_q <= r_q;
        r_q <= l_q ^ f_out;
      end
    end
  end

  assign blk_out = block_out_perm({l_q, r_q});

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(l_q) && $stable(r_q)));

endmodule

// File: rtl/tdes_core.sv
module tdes_core
  import tdes_pkg::*;
#(
  parameter int PASSES = 3,
  parameter int ROUNDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        decrypt,
  input  logic [63:0] key1,
  input  logic [63:0] key2,
  input  logic [63:0] key3,
  input  logic [63:0] din,
  output logic [63:0] dout,
  output logic        done
);
  localparam int RW = $clog2(ROUNDS);
  localparam int PW = $clog2(PASSES);

  logic          accept;
  logic          step;
  logic          last_rnd;
  logic          fin_rnd;
  logic          pass_dec;
  logic [RW-1:0] rnd;
  logic [PW-1:0] kidx_next;
  logic          ks_load;
  logic [CD_W-1:0]   cd_load;
  logic [SUBK_W-1:0] subkey;

  logic [BLK_W-1:0] key_in [PASSES];
  logic [CD_W-1:0]  kstore [PASSES];

  assign key_in[0] = key1;
  assign key_in[1] = key2;
  assign key_in[2] = key3;

  // Only the 56 effective bits of each key are stored.
  for (genvar g = 0; g < PASSES; g++) begin : g_kstore
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      kstore[g] <= '0;
      else if (accept) kstore[g] <= key_compress(key_in[g]);
    end
  end

  assign ks_load = accept || (step && last_rnd && !fin_rnd);
  assign cd_load = accept ? key_compress(decrypt ? key_in[PASSES-1] : key_in[0])
                          : kstore[kidx_next];

  tdes_sequencer #(.PASSES(PASSES), .ROUNDS(ROUNDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .decrypt   (decrypt),
    .accept    (accept),
    .step      (step),
    .last_rnd  (last_rnd),
    .fin_rnd   (fin_rnd),
    .pass_dec  (pass_dec),
    .rnd       (rnd),
    .kidx_next (kidx_next),
    .done      (done)
  );

  tdes_key_sched #(.ROUNDS(ROUNDS)) u_ks (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ks_load),
    .load_cd (cd_load),
    .step    (step),
    .last    (last_rnd),
    .dec     (pass_dec),
    .rnd     (rnd),
    .subkey  (subkey)
  );

  tdes_round_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .blk_in  (din),
    .step    (step),
    .last    (last_rnd),
    .subkey  (subkey),
    .blk_out (dout)
  );

endmodule

// File: tb/tdes_core_bench.sv
`timescale 1ns/1ps
module tdes_core_bench;
  import tdes_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        decrypt = 1'b0;
  logic [63:0] key1 = '0, key2 = '0, key3 = '0, din = '0;
  logic [63:0] dout;
  logic        done;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tdes_core u_tdes_core (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
    .key1(key1), .key2(key2), .key3(key3), .din(din), .dout(dout), .done(done)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // Model: subkeys built up front with cumulative rotations, reversed for decrypt.
  function automatic logic [31:0] ref_f(input logic [31:0] h, input logic [47:0] k);
    logic [47:0] x;
    logic [31:0] s;
    x = half_expand(h) ^ k;
    s = '0;
    for (int j = 0; j < 8; j++) begin
      s = {s[27:0], sbox_lookup(j, x[47:42])};
      x = x << 6;
    end
    return half_mix(s);
  endfunction

  function automatic logic [63:0] ref_des(input logic [63:0] key, input logic [63:0] blk, input bit dec);
    logic [47:0] sk [16];
    logic [55:0] cd;
    logic [63:0] lr;
    logic [31:0] l, r, t;
    cd = key_compress(key);
    for (int i = 0; i < 16; i++) begin
      cd = cd_rotl(cd, rot_step(i));
      sk[i] = subkey_pick(cd);
    end
    lr = block_in_perm(blk);
    l = lr[63:32];
    r = lr[31:0];
    for (int i = 0; i < 16; i++) begin
      t = r;
      r = l ^ ref_f(r, dec ? sk[15 - i] : sk[i]);
      l = t;
    end
    return block_out_perm({r, l});
  endfunction

  function automatic logic [63:0] ref_tdes(input logic [63:0] a, b, c, x, input bit dec);
    if (dec) return ref_des(a, ref_des(b, ref_des(c, x, 1'b1), 1'b0), 1'b1);
    return ref_des(c, ref_des(b, ref_des(a, x, 1'b0), 1'b1), 1'b0);
  endfunction

  // Called just after a falling edge; start is sampled on the next rising edge.
  task automatic do_op(input logic [63:0] a, b, c, x, input bit dec, input logic [63:0] exp,
                       input string rq, input bit disturb, input bit chain);
    bit early = 1'b0;
    key1 = a; key2 = b; key3 = c; din = x; decrypt = dec; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < 48; i++) begin
      @(negedge clk);
      if (done) early = 1'b1;
      if (disturb && i == 10) begin
        start = 1'b1; key1 = ~key1; key3 = ~key3; din = ~din; decrypt = ~dec;
      end
      if (disturb && i == 12) start = 1'b0;
    end
    chk(!early, "R6 done before 48th edge", {63'd0, early}, 64'd0);
    @(negedge clk);
    chk(done === 1'b1, "R6 done at 48th edge", {63'd0, done}, 64'd1);
    chk(dout === exp, rq, dout, exp);
    if (!chain) begin
      @(negedge clk);
      chk(done === 1'b0, "R6 done one cycle", {63'd0, done}, 64'd0);
      repeat (3) @(negedge clk);
      chk(dout === exp, "R8 result held", dout, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b, c, x, y, e, m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && dout === '0, "R1 during reset", dout, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R1 done after reset", {63'd0, done}, 64'd0);
    chk(dout === '0, "R1 dout after reset", dout, 64'd0);

    // R5: known single-DES answers with equal keys.
    a = 64'h133457799BBCDFF1;
    do_op(a, a, a, 64'h0123456789ABCDEF, 1'b0, 64'h85E813540F0AB405, "R5 known encrypt", 0, 0);
    do_op(a, a, a, 64'h85E813540F0AB405, 1'b1, 64'h0123456789ABCDEF, "R5 R3 known decrypt", 0, 0);
    a = 64'h0123456789ABCDEF;
    do_op(a, a, a, 64'h4E6F772069732074, 1'b0, 64'h3FA40E8A984D4815, "R5 second known vector", 0, 0);

    // R2 corner data patterns, and a two-key set (key3 = key1).
    a = 64'h0F1E2D3C4B5A6978; b = 64'hF0E1D2C3B4A59687;
    do_op(a, b, a, 64'h0, 1'b0, ref_tdes(a, b, a, 64'h0, 1'b0), "R2 zero block two-key", 0, 0);
    do_op(a, b, a, '1, 1'b0, ref_tdes(a, b, a, '1, 1'b0), "R2 ones block two-key", 0, 0);

    // Random sets: encrypt, then decrypt back (R2, R3); parity flips (R4);
    // mid-run disturbance (R7).
    for (int n = 0; n < 24; n++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      c = {$urandom, $urandom}; x = {$urandom, $urandom};
      e = ref_tdes(a, b, c, x, 1'b0);
      do_op(a, b, c, x, 1'b0, e, "R2 random encrypt", (n % 5) == 2, 0);
      if (n % 4 == 1) begin
        m = {$urandom, $urandom} & 64'h0101010101010101;
        do_op(a ^ m, b ^ 64'h0101010101010101, c ^ m, e, 1'b1, x, "R4 R3 parity-flipped decrypt", 0, 0);
      end else begin
        do_op(a, b, c, e, 1'b1, x, "R3 random decrypt round trip", (n % 5) == 4, 0);
      end
    end

    // R7: start pulses and input changes mid-run, directed.
    a = 64'hA5A5A5A5A5A5A5A5; b = 64'h5A5A5A5A5A5A5A5A; c = 64'h3C3C3C3CC3C3C3C3;
    x = 64'hDEADBEEFCAFEF00D;
    do_op(a, b, c, x, 1'b1, ref_tdes(a, b, c, x, 1'b1), "R7 disturbed decrypt", 1, 0);

    // R9: second start presented in the done cycle of the first.
    x = 64'h1122334455667788;
    y = 64'h99AABBCCDDEEFF00;
    do_op(a, b, c, x, 1'b0, ref_tdes(a, b, c, x, 1'b0), "R9 first of pair", 0, 1);
    do_op(c, a, b, y, 1'b1, ref_tdes(c, a, b, y, 1'b1), "R9 back-to-back second", 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule